// File: doc/BRIEF.md
# Character Tally Indirect Sequencer

This block resolves one character operand address through a tally indirect word held in memory. A request names the location of the indirect word and one of three stepping variants. The block reads that word through a ready/valid memory port and checks that its character offset is legal for the character size. It then presents the selected character position, meaning a word address plus a character offset within that word, to the operand path for exactly one cycle. For the two stepping variants it writes the updated indirect word back to the same location.

The forward variant uses the stored position first and advances afterwards. The reverse variant backs up first and uses the new position. In both cases the tally moves in the direction opposite to the pointer. A memory lock output covers the whole read-modify-write so the stepping update is indivisible. A zero-tally flag reports whether the last stepping update left the tally at zero. An offset that is out of range for the character size ends the sequence with a fault, and nothing is written.

Top module: `char_tally_seq`

## Requirements
- R1: Indirect word layout, with bit 35 as the most significant bit: word address in [35:18], tally in [17:6], size bit in [5] (1 = 9-bit characters, 0 = 6-bit), two spare bits in [4:3], character offset in [2:0]. Mode codes are 0 = plain, 1 = forward, 2 = reverse, and 3 behaves as plain. A plain request presents charWord=[35:18], charOffset=[2:0] and charSize9=[5], issues no memory write, and leaves tallyZero unchanged.
- R2: An offset above 5 with 6-bit characters, or above 3 with 9-bit characters, pulses fault together with done. In that case charValid is never raised and no write is issued. This applies in every mode.
- R3: Forward presents the stored position. It then increments the offset. When the offset was at its last value (5 for 6-bit, 3 for 9-bit), the offset becomes 0 and the word address increments modulo 2^18.
- R4: Forward writes back the tally decremented modulo 4096.
- R5: Reverse first decrements the offset. When the offset was 0, it becomes 5 (6-bit) or 3 (9-bit) and the word address decrements modulo 2^18. The new position is what is presented and written back.
- R6: Reverse writes back the tally incremented modulo 4096.
- R7: The write-back goes to the same address as the read and keeps bits [5:3] of the word that was read.
- R8: On completion of a forward or reverse request, tallyZero becomes 1 if the written tally is zero and 0 otherwise.
- R9: memLock is high from the read request of a stepping request through acceptance of its write. It is high at every write and low whenever the block is idle.
- R10: A request is accepted only while idle. A memory request holds until memReady. Each successful request raises charValid for exactly one cycle before a one-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (sampled while idle) |
| reqMode | input | 2 | 0 plain, 1 forward, 2 reverse, 3 plain |
| reqAddr | input | 18 | Location of the indirect word |
| busy | output | 1 | A request is in progress |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 18 | Memory word address |
| memWdata | output | 36 | Write data |
| memReady | input | 1 | Memory accepts the request; read data valid in the same cycle |
| memRdata | input | 36 | Read data |
| memLock | output | 1 | Holds memory for the read-modify-write |
| charValid | output | 1 | Character address valid this cycle |
| charWord | output | 18 | Character word address |
| charOffset | output | 3 | Character offset within the word |
| charSize9 | output | 1 | 1 = 9-bit characters, 0 = 6-bit |
| done | output | 1 | Request finished (one cycle) |
| fault | output | 1 | Illegal offset; qualifies done |
| tallyZero | output | 1 | Last stepping update left a zero tally |

## Verification
The assertions assume that memReady may stall for any number of cycles but that memRdata is valid whenever memReady is seen with a read request. They also assume that start is raised only while busy is low. The bench always waits for done before starting a new request. Its memory model places read data combinationally at the requested address, and it inserts alternate-cycle stalls for some requests, so the held-request and lock-window properties are exercised under back-pressure.

// File: rtl/ctseq_pkg.sv
package ctseq_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_FWD   = 2'd1,
    MODE_REV   = 2'd2,
    MODE_ALT   = 2'd3
  } stepMode_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CHECK = 3'd2,
    ST_EMIT  = 3'd3,
    ST_WRITE = 3'd4,
    ST_DONE  = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic updFlag;
  } dpCtl_t;

endpackage

// File: rtl/ctseq_dp.sv
module ctseq_dp
  import ctseq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int TALLY_W = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCtl_t                            ctl,
  input  logic [1:0]                        startMode,
  input  logic [ADDR_W-1:0]                 startAddr,
  input  logic [ADDR_W+TALLY_W+6-1:0]       memRdata,
  input  logic                              emitNow,
  output logic                              stepping,
  output logic                              offBad,
  output logic [ADDR_W-1:0]                 memAddr,
  output logic [ADDR_W+TALLY_W+6-1:0]       memWdata,
  output logic [ADDR_W-1:0]                 charWord,
  output logic [2:0]                        charOffset,
  output logic                              charSize9,
  output logic                              tallyZero
);

  localparam int WORD_W    = ADDR_W + TALLY_W + 6;
  localparam int TALLY_LSB = 6;
  localparam int ADDR_LSB  = TALLY_LSB + TALLY_W;

  stepMode_t             modeQ;
  logic [ADDR_W-1:0]     addrQ;
  logic [WORD_W-1:0]     capWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_PLAIN;
      addrQ   <= '0;
      capWord <= '0;
    end else begin
      if (ctl.latchReq) begin
        modeQ <= stepMode_t'(startMode);
        addrQ <= startAddr;
      end
      if (ctl.capture) capWord <= memRdata;
    end
  end

  // field split of the captured indirect word
  logic [ADDR_W-1:0]  curWord;
  logic [TALLY_W-1:0] curTally;
  logic               size9;
  logic [1:0]         spare;
  logic [2:0]         curOff;
  logic [2:0]         lastOff;

  assign curWord  = capWord[WORD_W-1:ADDR_LSB];
  assign curTally = capWord[ADDR_LSB-1:TALLY_LSB];
  assign size9    = capWord[5];
  assign spare    = capWord[4:3];
  assign curOff   = capWord[2:0];
  assign lastOff  = size9 ? 3'd3 : 3'd5;
  assign offBad   = curOff > lastOff;

  logic isRev;
  assign isRev    = (modeQ == MODE_REV);
  assign stepping = (modeQ == MODE_FWD) || isRev;

  // forward: post-increment; reverse: pre-decrement
  logic               fwdWrap, revWrap;
  logic [ADDR_W-1:0]  fwdWord, revWord;
  logic [2:0]         fwdOff, revOff;

  always_comb begin
    fwdWrap = (curOff == lastOff);
    revWrap = (curOff == 3'd0);
    fwdOff  = fwdWrap ? 3'd0 : curOff + 3'd1;
    fwdWord = fwdWrap ? curWord + ADDR_W'(1) : curWord;
    revOff  = revWrap ? lastOff : curOff - 3'd1;
    revWord = revWrap ? curWord - ADDR_W'(1) : curWord;
  end

  logic [ADDR_W-1:0]  newWord;
  logic [2:0]         newOff;
  logic [TALLY_W-1:0] newTally;

  assign newWord  = isRev ? revWord : fwdWord;
  assign newOff   = isRev ? revOff  : fwdOff;
  assign newTally = isRev ? curTally + TALLY_W'(1) : curTally - TALLY_W'(1);

  assign charWord   = isRev ? revWord : curWord;
  assign charOffset = isRev ? revOff  : curOff;
  assign charSize9  = size9;

  assign memAddr  = addrQ;
  assign memWdata = {newWord, newTally, size9, spare, newOff};

  always_ff @(posedge clk) begin
    if (!rstN)            tallyZero <= 1'b0;
    else if (ctl.updFlag) tallyZero <= (newTally == '0);
  end

  // R2
  emit_offset_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    emitNow |-> (charSize9 ? (charOffset <= 3'd3) : (charOffset <= 3'd5)));

  // R8
  flag_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updFlag |=> (tallyZero == ($past(memWdata[ADDR_LSB-1:TALLY_LSB]) == '0)));

endmodule

// File: rtl/ctseq_ctrl.sv
module ctseq_ctrl
  import ctseq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   memReady,
  input  logic   stepping,
  input  logic   offBad,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   memReq,
  output logic   memWe,
  output logic   memLock,
  output logic   charValid,
  output logic   done,
  output logic   fault
);

  seqState_t st, stNext;
  logic      faultQ;

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE:  if (start) stNext = ST_READ;
      ST_READ:  if (memReady) stNext = ST_CHECK;
      ST_CHECK: stNext = offBad ? ST_DONE : ST_EMIT;
      ST_EMIT:  stNext = stepping ? ST_WRITE : ST_DONE;
      ST_WRITE: if (memReady) stNext = ST_DONE;
      ST_DONE:  stNext = ST_IDLE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      faultQ <= 1'b0;
    end else begin
      st <= stNext;
      if (st == ST_IDLE)       faultQ <= 1'b0;
      else if (st == ST_CHECK) faultQ <= offBad;
    end
  end

  assign ctl.latchReq = (st == ST_IDLE) && start;
  assign ctl.capture  = (st == ST_READ) && memReady;
  assign ctl.updFlag  = (st == ST_WRITE) && memReady;

  assign busy      = (st != ST_IDLE);
  assign memReq    = (st == ST_READ) || (st == ST_WRITE);
  assign memWe     = (st == ST_WRITE);
  assign memLock   = stepping && ((st == ST_READ) || (st == ST_CHECK) ||
                                  (st == ST_EMIT) || (st == ST_WRITE));
  assign charValid = (st == ST_EMIT);
  assign done      = (st == ST_DONE);
  assign fault     = (st == ST_DONE) && faultQ;

  // R9
  lock_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memLock);

  // R9
  idle_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memLock);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe)));

  // R10
  single_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> !charValid);

  // R2
  fault_no_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (done && !$past(charValid)));

endmodule

// File: rtl/char_tally_seq.sv
module char_tally_seq
  import ctseq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int TALLY_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [1:0]                  reqMode,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic                        busy,
  output logic                        memReq,
  output logic                        memWe,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [ADDR_W+TALLY_W+5:0]   memWdata,
  input  logic                        memReady,
  input  logic [ADDR_W+TALLY_W+5:0]   memRdata,
  output logic                        memLock,
  output logic                        charValid,
  output logic [ADDR_W-1:0]           charWord,
  output logic [2:0]                  charOffset,
  output logic                        charSize9,
  output logic                        done,
  output logic                        fault,
  output logic                        tallyZero
);

  dpCtl_t ctl;
  logic   stepping;
  logic   offBad;

  ctseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memReady  (memReady),
    .stepping  (stepping),
    .offBad    (offBad),
    .ctl       (ctl),
    .busy      (busy),
    .memReq    (memReq),
    .memWe     (memWe),
    .memLock   (memLock),
    .charValid (charValid),
    .done      (done),
    .fault     (fault)
  );

  ctseq_dp #(.ADDR_W(ADDR_W), .TALLY_W(TALLY_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startMode  (reqMode),
    .startAddr  (reqAddr),
    .memRdata   (memRdata),
    .emitNow    (charValid),
    .stepping   (stepping),
    .offBad     (offBad),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .charWord   (charWord),
    .charOffset (charOffset),
    .charSize9  (charSize9),
    .tallyZero  (tallyZero)
  );

endmodule

// File: tb/test_char_tally_seq.sv
`timescale 1ns/1ps
module test_char_tally_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  reqMode = 2'd0;
  logic [17:0] reqAddr = '0;
  logic        busy, memReq, memWe, memLock, charValid, charSize9, done, fault, tallyZero;
  logic [17:0] memAddr, charWord;
  logic [35:0] memWdata, memRdata;
  logic [2:0]  charOffset;
  logic        memReady;
  logic        slowMem = 1'b0;
  logic        tog = 1'b0;

  logic [35:0] mem [0:63];
  int          writeCnt = 0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  char_tally_seq i_char_tally_seq (
    .clk(clk), .rstN(rstN), .start(start), .reqMode(reqMode), .reqAddr(reqAddr),
    .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .memLock(memLock), .charValid(charValid),
    .charWord(charWord), .charOffset(charOffset), .charSize9(charSize9), .done(done),
    .fault(fault), .tallyZero(tallyZero)
  );

  always @(posedge clk) tog <= ~tog;
  assign memReady = !slowMem || tog;
  assign memRdata = mem[memAddr[5:0]];

  always @(posedge clk) begin
    if (memReq && memReady && memWe) begin
      mem[memAddr[5:0]] <= memWdata;
      writeCnt = writeCnt + 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mk(logic [17:0] w, logic [11:0] t, logic s9,
                                     logic [1:0] sp, logic [2:0] o);
    return {w, t, s9, sp, o};
  endfunction

  // one request with full result checking
  task automatic runCase(string tag, logic [1:0] mode, logic [5:0] loc, logic [35:0] w,
                         logic slow);
    logic [17:0] wd;
    logic [11:0] tl;
    logic [2:0]  of, lastO;
    logic        s9, isFwd, isRev, bad;
    logic [17:0] eW, nW;
    logic [2:0]  eO, nO;
    logic [11:0] nT;
    logic        oldFlag;
    int          wr0, emits, cyc;
    logic [17:0] gotW;
    logic [2:0]  gotO;
    logic        gotS, gotF, lockOk;
    wd = w[35:18]; tl = w[17:6]; s9 = w[5]; of = w[2:0];
    lastO = s9 ? 3'd3 : 3'd5;
    bad = of > lastO;
    isFwd = (mode == 2'd1); isRev = (mode == 2'd2);
    eW = wd; eO = of; nW = wd; nO = of; nT = tl;
    if (isFwd) begin
      nT = tl - 12'd1;
      if (of == lastO) begin nO = 3'd0; nW = wd + 18'd1; end else nO = of + 3'd1;
    end else if (isRev) begin
      nT = tl + 12'd1;
      if (of == 3'd0) begin nO = lastO; nW = wd - 18'd1; end else nO = of - 3'd1;
      eW = nW; eO = nO;
    end
    mem[loc] = w;
    slowMem = slow;
    oldFlag = tallyZero;
    wr0 = writeCnt;
    emits = 0; gotW = '0; gotO = '0; gotS = 0; gotF = 0; lockOk = 1;
    start = 1'b1; reqMode = mode; reqAddr = {12'd0, loc};
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (charValid) begin emits++; gotW = charWord; gotO = charOffset; gotS = charSize9; end
      if (memReq && memWe && !memLock) lockOk = 0;
      if (memReq && !memWe && (isFwd || isRev) && !memLock) lockOk = 0;
      @(negedge clk);
      cyc++;
    end
    gotF = fault;
    chk({tag, " done"}, done, 1'b1);
    @(negedge clk);
    if (bad) begin
      chk({"R2 fault ", tag}, gotF, 1'b1);
      chk({"R2 no emit ", tag}, emits, 0);
      chk({"R2 no write ", tag}, writeCnt - wr0, 0);
      chk({"R2 mem kept ", tag}, mem[loc], w);
      chk({"R2 flag kept ", tag}, tallyZero, oldFlag);
    end else begin
      chk({"R10 no fault ", tag}, gotF, 1'b0);
      chk({"R10 one emit ", tag}, emits, 1);
      chk({tag, " word"}, gotW, eW);
      chk({tag, " offset"}, gotO, eO);
      chk({"R1 size ", tag}, gotS, s9);
      if (isFwd || isRev) begin
        chk({"R7 one write ", tag}, writeCnt - wr0, 1);
        chk({tag, " written"}, mem[loc], {nW, nT, w[5:3], nO});
        chk({"R8 flag ", tag}, tallyZero, nT == 12'd0);
        chk({"R9 lock ", tag}, lockOk, 1'b1);
      end else begin
        chk({"R1 no write ", tag}, writeCnt - wr0, 0);
        chk({"R1 mem kept ", tag}, mem[loc], w);
        chk({"R1 flag kept ", tag}, tallyZero, oldFlag);
      end
    end
    chk({"R9 idle unlocked ", tag}, memLock, 1'b0);
    slowMem = 1'b0;
  endtask

  task automatic testReset();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset lock", memLock, 0);
    chk("R10 reset req", memReq, 0);
    chk("R10 reset emit", charValid, 0);
    chk("R8 reset flag", tallyZero, 0);
  endtask

  task automatic testPlain();
    runCase("R1 plain 9b", 2'd0, 6'd1, mk(18'o123456, 12'd5, 1, 2'b10, 3'd2), 0);
    runCase("R1 mode3 6b", 2'd3, 6'd2, mk(18'o000777, 12'd0, 0, 2'b01, 3'd5), 0);
  endtask

  task automatic testForward();
    runCase("R3 fwd mid", 2'd1, 6'd3, mk(18'o001000, 12'd7, 1, 2'b11, 3'd1), 0);
    runCase("R3 fwd wrap9", 2'd1, 6'd4, mk(18'o001000, 12'd9, 1, 2'b00, 3'd3), 0);
    runCase("R3 fwd wrapTop", 2'd1, 6'd5, mk(18'o777777, 12'd3, 0, 2'b10, 3'd5), 0);
    runCase("R4 fwd to zero", 2'd1, 6'd6, mk(18'o000040, 12'd1, 0, 2'b01, 3'd4), 0);
    runCase("R1 plain after zero", 2'd0, 6'd7, mk(18'o000041, 12'd3, 0, 2'b00, 3'd0), 0);
    runCase("R4 fwd under", 2'd1, 6'd8, mk(18'o000050, 12'd0, 1, 2'b11, 3'd0), 0);
  endtask

  task automatic testReverse();
    runCase("R5 rev wrap6", 2'd2, 6'd9, mk(18'o000012, 12'd4, 0, 2'b11, 3'd0), 0);
    runCase("R5 rev bottom", 2'd2, 6'd10, mk(18'o000000, 12'd2, 1, 2'b01, 3'd0), 0);
    runCase("R5 rev mid", 2'd2, 6'd11, mk(18'o004400, 12'd20, 1, 2'b00, 3'd2), 0);
    runCase("R6 rev to zero", 2'd2, 6'd12, mk(18'o004401, 12'hFFF, 0, 2'b10, 3'd3), 0);
  endtask

  task automatic testFault();
    runCase("R2 fwd 6b off6", 2'd1, 6'd13, mk(18'o000100, 12'd5, 0, 2'b00, 3'd6), 0);
    runCase("R2 rev 9b off4", 2'd2, 6'd14, mk(18'o000200, 12'd5, 1, 2'b11, 3'd4), 0);
    runCase("R2 plain 6b off7", 2'd0, 6'd15, mk(18'o000300, 12'd5, 0, 2'b00, 3'd7), 0);
  endtask

  task automatic testStall();
    runCase("R10 fwd stalled", 2'd1, 6'd16, mk(18'o070000, 12'd30, 0, 2'b11, 3'd5), 1);
    runCase("R10 rev stalled", 2'd2, 6'd17, mk(18'o070001, 12'd1, 1, 2'b10, 3'd1), 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testForward();
    testReverse();
    testFault();
    testStall();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule